// File: doc/BRIEF.md
# Request-Queuing Round-Robin Arbiter

This block arbitrates among a parameterised number of requesters. Each requester signals work with single-cycle pulses and does not hold its line high. Every cycle in which a request line is high adds one unit to that requester's own saturating pending counter, so a requester may post a new request on every cycle. A registered decision stage picks one requester that still has work, issues a one-cycle grant pulse to it, and that pulse retires exactly one unit of its pending count.

Fairness comes from a stored rotating pointer. After requester i is granted, the next search begins at requester i+1 and wraps around. A requester therefore waits at most N-1 grants while it has work pending. If a request arrives while its counter is saturated and no grant to that requester retires a unit in the same cycle, the request is discarded and a drop flag is raised in that cycle.

The decision stage is a two-state machine. ARB_IDLE means no grant is being driven. ARB_GRANT means a grant pulse for the stored selection is on the output. The transitions are:
- IDLE_TO_GRANT: from ARB_IDLE when any requester has work.
- GRANT_TO_GRANT: from ARB_GRANT when work remains.
- GRANT_TO_IDLE: from ARB_GRANT when no work remains.
- IDLE_HOLD: stay in ARB_IDLE when nothing is pending.

Top module: `rr_queue_arb`

## Requirements
- R1: Synchronous active-high reset clears every pending counter, points the rotation at requester 0 and holds grant_o, full_o and drop_o at zero.
- R2: Each cycle with req_i[i] high counts as one request; four consecutive high cycles on one requester yield exactly four grant pulses to it.
- R3: A single request pulse in cycle t on an otherwise idle arbiter produces its grant in cycle t+2, not earlier.
- R4: At most one bit of grant_o is high in any cycle, and each grant pulse retires exactly one pending request.
- R5: grant_o stays all-zero while no requester has pending work.
- R6: After a grant to requester i, the next grant goes to the first requester with work found searching from i+1 upward, wrapping modulo N.
- R7: A pending counter never exceeds DEPTH (default 4), and full_o[i] is high exactly while requester i holds DEPTH pending requests.
- R8: A request to a full requester that is not granted in the same cycle is discarded, leaves its count unchanged, and raises drop_o[i] in that same cycle.
- R9: A request arriving in the same cycle as a grant to that requester leaves its count unchanged, is not dropped even when full, and keeps full_o high.
- R10: A request needs to be high for only one cycle to be served; the arbiter accepts a new request from each requester on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_REQ | One request per high cycle, bit i for requester i |
| grant_o | output | NUM_REQ | One-cycle grant pulse, bit i for requester i |
| full_o | output | NUM_REQ | Requester i holds DEPTH pending requests |
| drop_o | output | NUM_REQ | Request of requester i discarded this cycle |

## Verification
On every cycle, assertions check that at most one grant is high and that a grant lands only on a counter holding work. They also check that no counter passes DEPTH, and that both a dropped request and a request cancelled by its own grant leave the count as it was. The fair rotation order, the exact two-cycle latency and the one-grant-per-pulse accounting across bursts can only be shown by the bench's scenarios. There, a cycle-level scoreboard predicts every grant, full and drop value for single pulses, simultaneous pulses, back-to-back bursts and saturation under full load.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_GRANT = 1'b1
    } arb_state_e;
endpackage

// File: rtl/arb_req_counter.sv
module arb_req_counter #(
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic dec_i,
    output logic avail_o,
    output logic full_o,
    output logic drop_o
);
    logic [CW-1:0] cnt_q;
    logic          at_cap;

    assign at_cap  = (cnt_q == CW'(DEPTH));
    assign full_o  = at_cap;
    assign drop_o  = req_i && !dec_i && at_cap;
    // work left after any grant already on the output retires its unit
    assign avail_o = (cnt_q > CW'(dec_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (req_i && !dec_i && !at_cap) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (!req_i && dec_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    p_cap_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));
    p_grant_has_work_r5: assert property (@(posedge clk) disable iff (rst)
        dec_i |-> (cnt_q != '0));
    p_drop_keeps_count_r8: assert property (@(posedge clk) disable iff (rst)
        drop_o |=> (cnt_q == $past(cnt_q)));
    p_cancel_keeps_count_r9: assert property (@(posedge clk) disable iff (rst)
        (req_i && dec_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int NUM_REQ = 4,
    parameter int IW      = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [NUM_REQ-1:0] avail_i,
    input  logic [IW-1:0]      ptr_i,
    output logic               found_o,
    output logic [IW-1:0]      sel_o
);
    always_comb begin
        int idx;
        found_o = 1'b0;
        sel_o   = '0;
        for (int k = 0; k < NUM_REQ; k++) begin
            idx = (int'(ptr_i) + k) % NUM_REQ;
            if (!found_o && avail_i[idx]) begin
                found_o = 1'b1;
                sel_o   = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/rr_queue_arb.sv
module rr_queue_arb #(
    parameter int NUM_REQ = 4,
    parameter int DEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req_i,
    output logic [NUM_REQ-1:0] grant_o,
    output logic [NUM_REQ-1:0] full_o,
    output logic [NUM_REQ-1:0] drop_o
);
    import arb_pkg::*;

    localparam int IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    arb_state_e        state_q, state_d;
    logic [IW-1:0]     sel_q, ptr_q;
    logic [NUM_REQ-1:0] avail;
    logic              found;
    logic [IW-1:0]     pick;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REQ; gi++) begin : g_cnt
            arb_req_counter #(.DEPTH(DEPTH), .CW(CW)) u_cnt (
                .clk     (clk),
                .rst     (rst),
                .req_i   (req_i[gi]),
                .dec_i   (grant_o[gi]),
                .avail_o (avail[gi]),
                .full_o  (full_o[gi]),
                .drop_o  (drop_o[gi])
            );
        end
    endgenerate

    arb_rr_pick #(.NUM_REQ(NUM_REQ), .IW(IW)) u_pick (
        .avail_i (avail),
        .ptr_i   (ptr_q),
        .found_o (found),
        .sel_o   (pick)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  state_d = found ? ARB_GRANT : ARB_IDLE;
            ARB_GRANT: state_d = found ? ARB_GRANT : ARB_IDLE;
            default:   state_d = ARB_IDLE;
        endcase
    end

    // state register, selection and rotation pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            sel_q   <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (found) begin
                sel_q <= pick;
                ptr_q <= (pick == IW'(NUM_REQ - 1)) ? '0 : pick + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        grant_o = '0;
        unique case (state_q)
            ARB_GRANT: grant_o[sel_q] = 1'b1;
            default:   grant_o = '0;
        endcase
    end

    p_onehot_grant_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));
    p_idle_no_grant_r5: assert property (@(posedge clk) disable iff (rst)
        (avail == '0 && grant_o == '0) |=> (grant_o == '0));
endmodule

// File: tb/tb_rr_queue_arb.sv
module tb_rr_queue_arb;
    localparam int N = 4;
    localparam int D = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] grant_o, full_o, drop_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    rr_queue_arb #(.NUM_REQ(N), .DEPTH(D)) dut (
        .clk(clk), .rst(rst), .req_i(req_i),
        .grant_o(grant_o), .full_o(full_o), .drop_o(drop_o)
    );

    // reference model state
    int           mcnt [N];
    logic [N-1:0] mgrant;
    int           mptr;
    logic [N-1:0] exp_q [$];
    logic [N-1:0] obs_grant, obs_full;
    int           r9_hits;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compares grants after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [N-1:0] e;
            e = exp_q.pop_front();
            chk(grant_o == e, "R6 grant order", 32'(grant_o), 32'(e));
        end
    end

    // driver: one cycle of stimulus, model update, push expected grant
    task automatic step(input logic [N-1:0] r);
        logic [N-1:0] mfull, mdrop, nxt;
        bit           found;
        int           pick;
        @(negedge clk);
        obs_grant = grant_o;
        obs_full  = full_o;
        for (int i = 0; i < N; i++) mfull[i] = (mcnt[i] == D);
        chk(full_o == mfull, "R7 full flags", 32'(full_o), 32'(mfull));
        req_i = r;
        #0.5;
        for (int i = 0; i < N; i++) mdrop[i] = r[i] && !mgrant[i] && (mcnt[i] == D);
        chk(drop_o == mdrop, "R8 drop flags", 32'(drop_o), 32'(mdrop));
        for (int i = 0; i < N; i++) begin
            if (r[i] && mgrant[i] && mcnt[i] == D) begin
                r9_hits++;
                chk(drop_o[i] == 1'b0, "R9 no drop on coincident grant", 32'(drop_o[i]), 0);
            end
        end
        found = 0;
        pick  = 0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (mptr + k) % N;
            if (!found && mcnt[idx] > (mgrant[idx] ? 1 : 0)) begin
                found = 1;
                pick  = idx;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (r[i] && !mgrant[i] && mcnt[i] < D) mcnt[i]++;
            else if (!r[i] && mgrant[i]) mcnt[i]--;
        end
        nxt = '0;
        if (found) begin
            nxt[pick] = 1'b1;
            mptr = (pick + 1) % N;
        end
        mgrant = nxt;
        exp_q.push_back(nxt);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int gcount;
        bit saw_full, saw_drop;
        for (int i = 0; i < N; i++) mcnt[i] = 0;
        mgrant = '0; mptr = 0; r9_hits = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(grant_o == '0 && full_o == '0 && drop_o == '0, "R1 reset outputs",
            {20'd0, grant_o, full_o, drop_o}, 0);
        rst = 1'b0;

        // R3/R10: one pulse, grant two cycles later
        step(4'b0100);
        step(4'b0000);
        chk(obs_grant == '0, "R3 no grant at t+1", 32'(obs_grant), 0);
        step(4'b0000);
        chk(obs_grant == 4'b0100, "R3 grant at t+2 (R10 one-cycle pulse)", 32'(obs_grant), 4);
        step(4'b0000);
        chk(obs_grant == '0, "R4 single-cycle grant", 32'(obs_grant), 0);

        // R6: pointer now at 3; pulse 0,1,3 together
        step(4'b1011);
        step(4'b0000);
        step(4'b0000);
        chk(obs_grant == 4'b1000, "R6 first from pointer 3", 32'(obs_grant), 8);
        step(4'b0000);
        chk(obs_grant == 4'b0001, "R6 wrap to 0", 32'(obs_grant), 1);
        step(4'b0000);
        chk(obs_grant == 4'b0010, "R6 then 1", 32'(obs_grant), 2);

        // R2: four consecutive cycles give four grants
        gcount = 0;
        for (int c = 0; c < 4; c++) begin
            step(4'b0001);
            if (obs_grant[0]) gcount++;
        end
        for (int c = 0; c < 8; c++) begin
            step(4'b0000);
            if (obs_grant[0]) gcount++;
        end
        chk(gcount == 4, "R2 four pulses four grants", gcount, 4);

        // R5: nothing pending, no grants
        for (int c = 0; c < 4; c++) begin
            step(4'b0000);
            chk(obs_grant == '0, "R5 idle no grant", 32'(obs_grant), 0);
        end

        // R7/R8/R9: saturate all requesters
        saw_full = 0; saw_drop = 0;
        for (int c = 0; c < 14; c++) begin
            step(4'b1111);
            if (obs_full == 4'b1111) saw_full = 1;
            if (drop_o != '0) saw_drop = 1;
        end
        chk(saw_full, "R7 all counters reach full", 32'(saw_full), 1);
        chk(saw_drop, "R8 drop seen under saturation", 32'(saw_drop), 1);
        chk(r9_hits > 0, "R9 coincident grant while full exercised", r9_hits, 1);

        // drain: exactly DEPTH grants per requester remain
        gcount = 0;
        for (int c = 0; c < 24; c++) begin
            step(4'b0000);
            if (obs_grant != '0) gcount++;
        end
        chk(gcount == N * D, "R4 each grant retires one request", gcount, N * D);
        chk(obs_full == '0 && obs_grant == '0, "R7 drained", {obs_full, obs_grant}, 0);

        step(4'b0000);
        summary();
        $finish;
    end
endmodule